// File: doc/BRIEF.md
# Multichannel Serial Packet Link

This block carries a small group of independent, asynchronous single-bit level signals over one serial wire. It has no separate clock wire and no handshake. On the sending side, every channel first passes through a two-stage synchronizer. All channels are then captured together into one snapshot register, once per packet. The snapshot is framed and sent Manchester-encoded at one chip per clock, with packets following each other back to back.

On the receiving side, the chip stream is searched for a start pattern that no legal Manchester data can produce. The packet body that follows is collected, and three things are checked: every data symbol, the parity and the stop bit. A clean packet updates all output channels in a single cycle. A faulty packet is thrown away, the outputs keep their last value, and a one-cycle error pulse is raised.

The transmitter output and the receiver input are separate ports, so the integrator can place any serial channel between them. There is no back-pressure anywhere. The link streams continuously, and the output bus is a level-holding latch rather than a valid/ready stream, so a consumer simply reads it. Nothing needs configuring or training after reset.

Top module: `chan_serial_link`

## Requirements
- R1: Each channel input passes two synchronizing flops. All channels are then copied into the snapshot in the same clock cycle, once every packet period. The snapshot stays constant while its packet is being sent.
- R2: A packet is NCH+4 bit times = 2*(NCH+4) chips, one chip per clock, with packets back to back (20 cycles for NCH=6). The chip order is:
  - the start pattern: the chips 1,1,1,0, which fill two bit times and are not a legal Manchester pair;
  - data bits in order channel 0 first;
  - an even-parity bit, so that the data plus the parity bit hold an even number of ones;
  - a stop bit of value 1.
  A data bit 1 is sent as chip 1 then chip 0, and a data bit 0 as chip 0 then chip 1.
- R3: The receiver aligns itself only by finding the five-chip window 0,1,1,1,0, which is the second stop chip followed by the start pattern. No training sequence is needed: the first clean packet after reset updates the outputs.
- R4: A clean packet updates all output channels in the same clock edge, so no intermediate mix of old and new channel values ever appears on `ch_out`.
- R5: A level held on `ch_in` appears on `ch_out` within 48 clock cycles. Any input level held for at least 2*(NCH+4) cycles is always seen on `ch_out`.
- R6: A packet is discarded if any of its body chip pairs is not complementary, its parity is odd, or its stop bit is not 1. For a discarded packet `ch_out` keeps its value and `frame_err` is high for exactly one cycle. Clean traffic never raises `frame_err`.
- R7: After a framing error, including a truncated packet, the receiver hunts again for the start window. A later clean packet is decoded normally.
- R8: While reset is active and until the first packet is decoded, `ch_out` equals the default level (every bit equal to DEFAULT_HIGH, which defaults to 1). During reset, `frame_err` and `ser_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one chip per cycle |
| rst_n | input | 1 | Active-low reset |
| ch_in | input | NCH | Asynchronous channel levels to send |
| ser_out | output | 1 | Manchester chip stream from the transmitter |
| ser_in | input | 1 | Chip stream into the receiver |
| ch_out | output | NCH | Latched channel levels from the last clean packet |
| frame_err | output | 1 | One-cycle pulse when a packet is discarded |

## Verification
The bench sweeps all channel values in loopback. It watches for any intermediate output value, which is what a receiver that updates channels one by one would leave behind. It also moves a minimum-width pulse on each channel across every phase of the packet period. A snapshot taken at the wrong point, or a snapshot allowed to change during a packet, would miss some of those pulses.

Corrupted packets are injected directly on `ser_in`: flipped parity, a stop bit of 0, a data symbol with two equal chips, and a truncated packet. The bench checks that the outputs hold, that exactly one error pulse appears, and that the receiver locks again. A receiver that resumed from the stale position would decode garbage or never recover. The raw chip stream is also checked against the packet format and the 20-cycle period.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic {RX_HUNT, RX_RECV} rx_state_e;
  // Five-chip window: second stop chip (0) then the start pattern 1,1,1,0.
  localparam logic [4:0] SYNC_WIN = 5'b01110;
  localparam logic [3:0] START_CHIPS = 4'b1110;
endpackage

// File: rtl/link_in_sync.sv
module link_in_sync #(
  parameter int NCH = 6,
  parameter logic [NCH-1:0] RST_VAL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_async,
  output logic [NCH-1:0] d_sync
);
  logic [NCH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int NCH = 6,
  parameter logic [NCH-1:0] RST_VAL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_sync,
  output logic           ser_o
);
  import link_pkg::*;
  localparam int PKT_BITS  = NCH + 4;
  localparam int PKT_CHIPS = 2 * PKT_BITS;
  localparam int CW        = $clog2(PKT_CHIPS);
  localparam logic [CW-1:0] LAST = CW'(PKT_CHIPS - 1);

  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] snap_q;
  logic           ser_q;
  logic [NCH+1:0] payload;
  logic [CW-2:0]  bit_n;
  logic           half;
  logic           pay_bit;
  logic           chip_d;

  // payload bit order: data (ch0 first), even parity, stop
  assign payload = {1'b1, ^snap_q, snap_q};
  assign bit_n   = cnt_q[CW-1:1];
  assign half    = cnt_q[0];

  always_comb begin
    pay_bit = 1'b1;
    for (int j = 0; j < NCH + 2; j++) begin
      if (int'(bit_n) == j + 2) pay_bit = payload[j];
    end
  end

  always_comb begin
    if (int'(bit_n) < 2) chip_d = START_CHIPS[3 - int'(cnt_q)];
    else                 chip_d = pay_bit ^ half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= RST_VAL;
      ser_q  <= 1'b0;
    end else begin
      ser_q <= chip_d;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        snap_q <= ch_sync;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ser_o = ser_q;

  // R1: the snapshot only moves at a packet boundary
  p_snap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(snap_q))
    else $error("snapshot changed inside a packet");

  // R2: second chip of every payload bit is the complement of the first
  p_manchester_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_q[0] && (int'(cnt_q) >= 6)) |-> (ser_q != $past(ser_q)))
    else $error("payload symbol is not a Manchester pair");
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int NCH = 6,
  parameter logic [NCH-1:0] RST_VAL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_i,
  output logic [NCH-1:0] ch_o,
  output logic           err_o
);
  import link_pkg::*;
  localparam int BODY = 2 * (NCH + 2);
  localparam int BW   = $clog2(BODY);
  localparam logic [BW-1:0] LASTB = BW'(BODY - 1);

  rx_state_e       st_q;
  logic [3:0]      hist_q;
  logic [4:0]      win;
  logic [BW-1:0]   cnt_q;
  logic [BODY-2:0] body_q;
  logic [BODY-1:0] body_full;
  logic [NCH+1:0]  sym;
  logic [NCH+1:0]  pair_ok;
  logic            pkt_good;
  logic [NCH-1:0]  ch_q;
  logic            err_q;

  assign win       = {hist_q, ser_i};
  assign body_full = {body_q, ser_i};

  // oldest chip is the MSB of body_full
  for (genvar j = 0; j < NCH + 2; j++) begin : g_pair
    assign sym[j]     = body_full[BODY-1-2*j];
    assign pair_ok[j] = body_full[BODY-1-2*j] ^ body_full[BODY-2-2*j];
  end

  assign pkt_good = (&pair_ok) && !(^sym[NCH:0]) && sym[NCH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      hist_q <= '0;
      cnt_q  <= '0;
      body_q <= '0;
      ch_q   <= RST_VAL;
      err_q  <= 1'b0;
    end else begin
      hist_q <= win[3:0];
      err_q  <= 1'b0;
      case (st_q)
        RX_HUNT: begin
          if (win == SYNC_WIN) begin
            st_q  <= RX_RECV;
            cnt_q <= '0;
          end
        end
        RX_RECV: begin
          body_q <= body_full[BODY-2:0];
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LASTB) begin
            st_q <= RX_HUNT;
            if (pkt_good) ch_q  <= sym[NCH-1:0];
            else          err_q <= 1'b1;
          end
        end
        default: st_q <= RX_HUNT;
      endcase
    end
  end

  assign ch_o  = ch_q;
  assign err_o = err_q;

  // R6: a discarded packet leaves the outputs untouched
  p_hold_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(ch_q))
    else $error("outputs changed on a framing error");

  // R6: the error flag is a single-cycle pulse
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q)
    else $error("frame error longer than one cycle");

  // R4: outputs only change at the end of a received packet
  p_update_on_recv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_q) |-> ($past(st_q) == RX_RECV))
    else $error("outputs changed outside packet completion");

  // R7: after every packet end the receiver hunts again
  p_rehunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_RECV && cnt_q == LASTB) |=> (st_q == RX_HUNT))
    else $error("receiver did not return to hunting");
endmodule

// File: rtl/chan_serial_link.sv
module chan_serial_link #(
  parameter int   NCH          = 6,
  parameter logic DEFAULT_HIGH = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_in,
  output logic           ser_out,
  input  logic           ser_in,
  output logic [NCH-1:0] ch_out,
  output logic           frame_err
);
  localparam logic [NCH-1:0] RST_VAL = {NCH{DEFAULT_HIGH}};

  logic [NCH-1:0] ch_sync;

  link_in_sync #(.NCH(NCH), .RST_VAL(RST_VAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ch_in), .d_sync(ch_sync)
  );

  link_tx #(.NCH(NCH), .RST_VAL(RST_VAL)) u_tx (
    .clk(clk), .rst_n(rst_n), .ch_sync(ch_sync), .ser_o(ser_out)
  );

  link_rx #(.NCH(NCH), .RST_VAL(RST_VAL)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_i(ser_in), .ch_o(ch_out), .err_o(frame_err)
  );
endmodule

// File: tb/tb_chan_serial_link.sv
`timescale 1ns/1ps
module tb_chan_serial_link;
  localparam int NCH  = 6;
  localparam int PKT  = 2 * (NCH + 4);
  localparam int BODY = 2 * (NCH + 2);
  localparam int LAT  = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_in = 6'h2D;
  logic ser_out, ser_in, frame_err;
  logic [NCH-1:0] ch_out;
  logic inj_mode = 1'b0, inj_chip = 1'b0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  assign ser_in = inj_mode ? inj_chip : ser_out;
  always #2.5 clk = ~clk;

  chan_serial_link #(.NCH(NCH), .DEFAULT_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .ser_out(ser_out),
    .ser_in(ser_in), .ch_out(ch_out), .frame_err(frame_err)
  );

  int err_pulses = 0, skew_bad = 0, sel = 0;
  logic [NCH-1:0] applied = '0, prev_out = '0;
  logic track_skew = 1'b0, track_pulse = 1'b0, seen = 1'b0;

  always @(negedge clk) begin
    if (frame_err) err_pulses++;
    if (track_skew && ch_out != prev_out && ch_out != applied) skew_bad++;
    prev_out = ch_out;
    if (track_pulse && ch_out[sel]) seen = 1'b1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BODY-1:0] exp_body(input logic [NCH-1:0] v);
    logic [NCH+1:0] p;
    logic [BODY-1:0] b;
    p = {1'b1, ^v, v};
    for (int j = 0; j < NCH + 2; j++) begin
      b[BODY-1-2*j] = p[j];
      b[BODY-2-2*j] = ~p[j];
    end
    return b;
  endfunction

  // kind: 0 clean, 1 parity flipped, 2 stop bit 0, 3 equal chips in data bit 2
  task automatic send_pkt(input logic [NCH-1:0] v, input int kind, input int keep);
    logic [BODY-1:0] b;
    logic [PKT-1:0] chips;
    b = exp_body(v);
    if (kind == 1) begin
      b[BODY-1-2*NCH] = ~b[BODY-1-2*NCH];
      b[BODY-2-2*NCH] = ~b[BODY-2-2*NCH];
    end
    if (kind == 2) begin b[1] = 1'b0; b[0] = 1'b1; end
    if (kind == 3) b[BODY-2-4] = b[BODY-1-4];
    chips = {4'b1110, b};
    for (int i = 0; i < keep; i++) begin
      inj_chip = chips[PKT-1-i];
      @(negedge clk);
    end
  endtask

  task automatic grab_check(input logic [NCH-1:0] v);
    logic [4:0] w;
    logic [BODY-1:0] got;
    int n;
    ch_in = v;
    repeat (LAT + 2) @(negedge clk);
    w = '0;
    for (int i = 0; i < 3 * PKT && w != 5'b01110; i++) begin
      @(negedge clk);
      w = {w[3:0], ser_out};
    end
    chk("R2", "start window found", int'(w), 32'h0E);
    got = '0;
    for (int i = 0; i < BODY; i++) begin
      @(negedge clk);
      got = {got[BODY-2:0], ser_out};
      w = {w[3:0], ser_out};
    end
    chk("R2", "packet body chips", int'(got), int'(exp_body(v)));
    n = BODY;
    while (w != 5'b01110 && n < 3 * PKT) begin
      @(negedge clk);
      w = {w[3:0], ser_out};
      n++;
    end
    chk("R2", "packet period in cycles", n, PKT);
  endtask

  task automatic err_case(input int kind, input logic [NCH-1:0] a,
                          input logic [NCH-1:0] bad, input logic [NCH-1:0] c);
    send_pkt(a, 0, PKT);
    send_pkt(a, 0, PKT);
    repeat (2) @(negedge clk);
    chk("R6", "value before error", int'(ch_out), int'(a));
    err_pulses = 0;
    send_pkt(bad, kind, PKT);
    repeat (2) @(negedge clk);
    chk("R6", $sformatf("output held, kind %0d", kind), int'(ch_out), int'(a));
    chk("R6", $sformatf("one error pulse, kind %0d", kind), err_pulses, 1);
    send_pkt(c, 0, PKT);
    send_pkt(c, 0, PKT);
    repeat (2) @(negedge clk);
    chk("R7", $sformatf("relock after kind %0d", kind), int'(ch_out), int'(c));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    // R8: reset state
    repeat (5) @(negedge clk);
    chk("R8", "ch_out in reset", int'(ch_out), 32'h3F);
    chk("R8", "frame_err in reset", int'(frame_err), 0);
    chk("R8", "ser_out in reset", int'(ser_out), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8", "default before first packet", int'(ch_out), 32'h3F);
    // R3: no training, first packets deliver the input
    repeat (LAT - 8) @(negedge clk);
    chk("R3", "first input value after reset", int'(ch_out), 32'h2D);

    // R2: raw packet format and period
    grab_check(6'h00);
    grab_check(6'h3F);
    grab_check(6'h15);
    grab_check(6'h2A);

    // R5/R4: exhaustive value sweep in loopback, watching for skew
    err_pulses = 0;
    track_skew = 1'b1;
    for (int v = 0; v < (1 << NCH); v++) begin
      applied = NCH'(v);
      ch_in = NCH'(v);
      repeat (LAT) @(negedge clk);
      chk("R5", $sformatf("value %0h within latency", v), int'(ch_out), v);
    end
    track_skew = 1'b0;
    chk("R4", "no intermediate output values", skew_bad, 0);
    chk("R6", "no errors on clean traffic", err_pulses, 0);

    // R5: minimum-width pulse on every channel at every packet phase
    ch_in = '0;
    repeat (LAT) @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      for (int off = 0; off < PKT; off++) begin
        sel = k;
        repeat (off) @(negedge clk);
        seen = 1'b0;
        track_pulse = 1'b1;
        ch_in[k] = 1'b1;
        repeat (PKT) @(negedge clk);
        ch_in = '0;
        repeat (LAT + 2) @(negedge clk);
        track_pulse = 1'b0;
        chk("R5", $sformatf("pulse ch%0d phase %0d captured", k, off), int'(seen), 1);
      end
    end

    // R6/R7: injected faults
    inj_chip = 1'b0;
    inj_mode = 1'b1;
    send_pkt(6'h00, 0, PKT);
    err_case(1, 6'h0A, 6'h35, 6'h11);
    err_case(2, 6'h11, 6'h2E, 6'h3C);
    err_case(3, 6'h3C, 6'h03, 6'h21);

    // R7: truncated packet then relock
    send_pkt(6'h21, 0, PKT);
    repeat (1) @(negedge clk);
    err_pulses = 0;
    send_pkt(6'h1B, 0, 8);
    send_pkt(6'h36, 0, PKT);
    send_pkt(6'h36, 0, PKT);
    repeat (2) @(negedge clk);
    chk("R7", "relock after truncated packet", int'(ch_out), 32'h36);
    chk("R7", "truncation gives one error", err_pulses, 1);

    done = 1'b1;
    finish_run();
  end
endmodule